// File: doc/BRIEF.md
# PCI Configuration Space Register File

This block holds the 256-byte configuration header of a single PCI function and serves configuration cycles that arrive on a routed port. Every access carries a 24-bit address that names a bus, a device/function pair and a byte offset. The block claims only accesses whose bus and device/function equal its own parameters. A read to any other target returns all ones, and a write to any other target is discarded. Reads of one, two or four bytes come back one cycle later, packed little-endian.

Writes pass through a per-byte filter that depends on the header-type byte. That byte selects either the ordinary endpoint layout or the bridge layout. Identity, class, header-type and interrupt-pin bytes are protected. Reserved command and status bits are forced to zero. A full-dword write to a base or expansion-ROM register skips the filter and is stored with the bits below the region size cleared. An optional capability window sends accesses that fall inside it to a side port. A one-cycle remap strobe tells the address decoders downstream that the command register or a base register has changed. In the bridge layout the block also keeps the secondary bus number.

Top module: `cfgsp_top`

## Requirements
- R1: An access is claimed only when address bits [23:16] equal BUS_NUM and bits [15:8] equal DEVFN. An unclaimed read returns 0xFFFFFFFF. An unclaimed write changes nothing.
- R2: A read presented in cycle N raises rd_valid for exactly one cycle in N+1, with rd_data valid in that cycle. Bytes are assembled little-endian (lowest offset in bits [7:0]) and zero-extended. The acc_size codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes.
- R3: A four-byte read at an offset above 0xFC narrows to two bytes if the offset is at most 0xFE, and to one byte otherwise. A two-byte read at 0xFF narrows to one byte.
- R4: After reset the array holds the following, and every other byte is zero:
  - VENDOR_ID at 0x00–0x01 and DEVICE_ID at 0x02–0x03.
  - HDR_TYPE at 0x0E.
  - When CAP_EN is set, status bit 4 (byte 0x06) and the window start in byte 0x34.
- R5: A four-byte write at 0x10–0x27 or 0x30–0x33 stores the dword with bits below the region size cleared. Base registers use BASE_LOG2. Offsets 0x30 and up use ROM_LOG2 and keep bit 0. The remap strobe rises the next cycle.
- R6: Other writes go byte by byte. Bytes above 0xFF are dropped.
  - In every layout 0x00–0x03, 0x08–0x0B, 0x0E, 0x2C–0x2F and 0x3D are read-only.
  - When HDR_TYPE[6:0] is 1 (bridge), 0x38–0x3B is also read-only.
  - Otherwise 0x10–0x33 is also read-only.
- R7: A byte written to 0x05 has bits 0xF8 cleared. A byte written to 0x06 has bits 0x47 cleared and keeps its previous bit 4. A byte written to 0x07 has bits 0x06 cleared.
- R8: Any byte-path write whose span includes offset 0x04 or 0x05 raises remap for one cycle after the access.
- R9: When CAP_EN is set, a claimed access with offset ≥ CAP_START and offset+bytes < CAP_START+CAP_LEN raises cap_sel in the same cycle and leaves the array alone. A read of this kind returns cap_rdata one cycle later.
- R10: In the bridge layout a claimed, non-window write updates sec_bus. A write starting at 0x19 loads wdata[7:0]. A write of two or more bytes starting at 0x18 loads wdata[15:8]. sec_bus otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Configuration access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | {bus, devfn, offset} |
| acc_size | input | 2 | 0 = byte, 1 = halfword, 2/3 = dword |
| acc_wdata | input | 32 | Write data, lowest offset in bits [7:0] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| remap | output | 1 | One-cycle strobe: decode-relevant registers changed |
| sec_bus | output | 8 | Secondary bus number (bridge layout) |
| cap_sel | output | 1 | Access diverted to capability port |
| cap_write | output | 1 | Direction of diverted access |
| cap_off | output | 8 | Offset of diverted access |
| cap_size | output | 2 | Size code of diverted access |
| cap_wdata | output | 32 | Write data of diverted access |
| cap_rdata | input | 32 | Capability read data, sampled in the access cycle |

## Verification
Two instances share one stimulus stream: an endpoint with the window enabled and a bridge without it. Each access is therefore a hit for one instance and a miss for the other. Byte, halfword and dword writes are aimed at protected identity bytes, base registers, the ROM register and the command/status pair. These show whether the layout-specific filter, the size masking and the reserved-bit clearing are applied to the right lanes. Reads near 0xFF and around both edges of the window separate correct width narrowing and a correct strict upper window bound from off-by-one decodes. Writes at 0x18 and 0x19 on both instances show whether only the bridge tracks the secondary bus.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam logic [7:0] OFF_CMD_LO  = 8'h04;
    localparam logic [7:0] OFF_CMD_HI  = 8'h05;
    localparam logic [7:0] OFF_STS_LO  = 8'h06;
    localparam logic [7:0] OFF_STS_HI  = 8'h07;
    localparam logic [7:0] OFF_HDR     = 8'h0E;
    localparam logic [7:0] OFF_BUSREGS = 8'h18;
    localparam logic [7:0] OFF_SECBUS  = 8'h19;
    localparam logic [7:0] OFF_ROMBASE = 8'h30;
    localparam logic [7:0] OFF_CAPPTR  = 8'h34;

    localparam logic [7:0] CMD_HI_RSVD = 8'hF8;
    localparam logic [7:0] STS_LO_RSVD = 8'h47;
    localparam logic [7:0] STS_HI_RSVD = 8'h06;
    localparam logic [7:0] STS_LO_KEEP = 8'h10;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } size_e;

    typedef struct packed {
        logic       hit;
        logic       base_wr;
        logic       byte_wr;
        logic       to_cap;
        logic       cmd_touch;
        logic [2:0] nbytes;
        logic [7:0] off;
    } dec_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (size_e'(sz))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic byte_writable(input logic [7:0] a, input logic bridge);
        logic ro;
        ro = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == OFF_HDR) ||
             (a == 8'h3D) || (a >= 8'h2C && a <= 8'h2F);
        if (bridge) ro = ro || (a >= 8'h38 && a <= 8'h3B);
        else        ro = ro || (a >= 8'h10 && a <= 8'h33);
        return !ro;
    endfunction

    function automatic logic [7:0] rsvd_mask(input logic [7:0] a);
        case (a)
            OFF_CMD_HI: return CMD_HI_RSVD;
            OFF_STS_LO: return STS_LO_RSVD;
            OFF_STS_HI: return STS_HI_RSVD;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] keep_mask(input logic [7:0] a);
        return (a == OFF_STS_LO) ? STS_LO_KEEP : 8'h00;
    endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
    import cfgsp_pkg::*;
#(
    parameter int unsigned BUS_NUM   = 0,
    parameter int unsigned DEVFN     = 8,
    parameter int unsigned CAP_EN    = 1,
    parameter int unsigned CAP_START = 64,
    parameter int unsigned CAP_LEN   = 16
) (
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [23:0] acc_addr,
    input  logic [1:0]  acc_size,
    output dec_t        dec
);
    localparam logic [9:0] CAP_LO = 10'(CAP_START);
    localparam logic [9:0] CAP_HI = 10'(CAP_START + CAP_LEN);

    logic [9:0] end_off;
    logic       in_base;
    logic       in_cap;

    always_comb begin
        dec.off    = acc_addr[7:0];
        dec.nbytes = size_bytes(acc_size);
        end_off    = {2'b00, dec.off} + {7'b0, dec.nbytes};
        dec.hit    = acc_valid && (acc_addr[23:16] == 8'(BUS_NUM)) &&
                     (acc_addr[15:8] == 8'(DEVFN));
        in_base    = (dec.nbytes == 3'd4) &&
                     ((dec.off >= 8'h10 && dec.off <= 8'h27) ||
                      (dec.off >= OFF_ROMBASE && dec.off <= 8'h33));
        in_cap     = (CAP_EN != 0) && ({2'b00, dec.off} >= CAP_LO) && (end_off < CAP_HI);
        dec.base_wr   = dec.hit && acc_write && in_base;
        dec.to_cap    = dec.hit && in_cap && !dec.base_wr;
        dec.byte_wr   = dec.hit && acc_write && !in_base && !in_cap;
        dec.cmd_touch = (dec.off <= OFF_CMD_HI) && (end_off > {2'b00, OFF_CMD_LO});
    end
endmodule

// File: rtl/cfgsp_store.sv
module cfgsp_store
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter logic [15:0] DEVICE_ID = 16'h1234,
    parameter logic [7:0]  HDR_TYPE  = 8'h00,
    parameter int unsigned CAP_EN    = 1,
    parameter int unsigned CAP_START = 64,
    parameter int unsigned BASE_LOG2 = 8,
    parameter int unsigned ROM_LOG2  = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  off,
    input  logic [2:0]  nbytes,
    input  logic        base_wr,
    input  logic        byte_wr,
    input  logic [31:0] wdata,
    output logic [31:0] rd_word,
    output logic        is_bridge
);
    localparam int unsigned NBYTES    = 256;
    localparam int unsigned LANES     = 4;
    localparam logic [31:0] BASE_MASK = ~((32'd1 << BASE_LOG2) - 32'd1);
    localparam logic [31:0] ROM_MASK  = ~((32'd1 << ROM_LOG2) - 32'd1) | 32'd1;

    logic [7:0]  mem [NBYTES];
    logic [8:0]  waddr [LANES];
    logic [7:0]  wbyte [LANES];
    logic        wen   [LANES];
    logic [31:0] masked;
    logic [7:0]  r0, r1, r2, r3;

    function automatic logic [7:0] reset_byte(input int unsigned i);
        if (i == 0)                         return VENDOR_ID[7:0];
        if (i == 1)                         return VENDOR_ID[15:8];
        if (i == 2)                         return DEVICE_ID[7:0];
        if (i == 3)                         return DEVICE_ID[15:8];
        if (i == int'(OFF_HDR))             return HDR_TYPE;
        if (i == int'(OFF_STS_LO) && CAP_EN != 0) return STS_LO_KEEP;
        if (i == int'(OFF_CAPPTR) && CAP_EN != 0) return 8'(CAP_START);
        return 8'h00;
    endfunction

    assign is_bridge = (mem[OFF_HDR][6:0] == 7'h01);

    always_comb begin
        masked = wdata & ((off >= OFF_ROMBASE) ? ROM_MASK : BASE_MASK);
        for (int i = 0; i < LANES; i++) begin
            waddr[i] = {1'b0, off} + 9'(i);
            if (base_wr) begin
                wen[i]   = 1'b1;
                wbyte[i] = masked[8*i +: 8];
            end else begin
                wen[i]   = byte_wr && (3'(i) < nbytes) && !waddr[i][8] &&
                           byte_writable(waddr[i][7:0], is_bridge);
                wbyte[i] = (wdata[8*i +: 8] & ~(rsvd_mask(waddr[i][7:0]) |
                                                keep_mask(waddr[i][7:0]))) |
                           (mem[waddr[i][7:0]] & keep_mask(waddr[i][7:0]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= reset_byte(i);
        end else begin
            for (int i = 0; i < LANES; i++)
                if (wen[i]) mem[waddr[i][7:0]] <= wbyte[i];
        end
    end

    always_comb begin
        r0 = mem[off];
        r1 = mem[off + 8'd1];
        r2 = mem[off + 8'd2];
        r3 = mem[off + 8'd3];
        if (nbytes == 3'd4 && off <= 8'hFC)      rd_word = {r3, r2, r1, r0};
        else if (nbytes >= 3'd2 && off <= 8'hFE) rd_word = {16'h0, r1, r0};
        else                                     rd_word = {24'h0, r0};
    end
endmodule

// File: rtl/cfgsp_top.sv
module cfgsp_top
    import cfgsp_pkg::*;
#(
    parameter int unsigned BUS_NUM   = 0,
    parameter int unsigned DEVFN     = 8,
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter logic [15:0] DEVICE_ID = 16'h1234,
    parameter logic [7:0]  HDR_TYPE  = 8'h00,
    parameter int unsigned CAP_EN    = 1,
    parameter int unsigned CAP_START = 64,
    parameter int unsigned CAP_LEN   = 16,
    parameter int unsigned BASE_LOG2 = 8,
    parameter int unsigned ROM_LOG2  = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [23:0] acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        remap,
    output logic [7:0]  sec_bus,
    output logic        cap_sel,
    output logic        cap_write,
    output logic [7:0]  cap_off,
    output logic [1:0]  cap_size,
    output logic [31:0] cap_wdata,
    input  logic [31:0] cap_rdata
);
    dec_t        dec;
    logic [31:0] rd_word;
    logic        is_bridge;

    cfgsp_decode #(
        .BUS_NUM(BUS_NUM), .DEVFN(DEVFN), .CAP_EN(CAP_EN),
        .CAP_START(CAP_START), .CAP_LEN(CAP_LEN)
    ) decode_i (
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .dec(dec)
    );

    cfgsp_store #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .HDR_TYPE(HDR_TYPE),
        .CAP_EN(CAP_EN), .CAP_START(CAP_START),
        .BASE_LOG2(BASE_LOG2), .ROM_LOG2(ROM_LOG2)
    ) store_i (
        .clk(clk), .rst(rst), .off(dec.off), .nbytes(dec.nbytes),
        .base_wr(dec.base_wr), .byte_wr(dec.byte_wr), .wdata(acc_wdata),
        .rd_word(rd_word), .is_bridge(is_bridge)
    );

    assign cap_sel   = dec.to_cap;
    assign cap_write = acc_write;
    assign cap_off   = acc_addr[7:0];
    assign cap_size  = acc_size;
    assign cap_wdata = acc_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
            remap    <= 1'b0;
            sec_bus  <= 8'h00;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write)
                rd_data <= !dec.hit ? 32'hFFFF_FFFF : (dec.to_cap ? cap_rdata : rd_word);
            remap <= dec.base_wr || (dec.byte_wr && dec.cmd_touch);
            if (is_bridge && dec.hit && acc_write && !dec.to_cap) begin
                if (dec.off == OFF_SECBUS)
                    sec_bus <= acc_wdata[7:0];
                else if (dec.off == OFF_BUSREGS && dec.nbytes > 3'd1)
                    sec_bus <= acc_wdata[15:8];
            end
        end
    end
endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker #(
    parameter int unsigned BUS_NUM   = 0,
    parameter int unsigned DEVFN     = 8,
    parameter int unsigned CAP_START = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [23:0] acc_addr,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        remap,
    input logic [7:0]  sec_bus,
    input logic        cap_sel,
    input logic [7:0]  cap_off
);
    localparam logic [15:0] SELF = {8'(BUS_NUM), 8'(DEVFN)};

    AST_MISS_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[23:8] != SELF) |=> (rd_data == 32'hFFFF_FFFF)); // R1
    AST_READ_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid); // R2
    AST_NO_SPURIOUS_RDV: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> !rd_valid); // R2
    AST_REMAP_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        remap |-> $past(acc_valid && acc_write)); // R5
    AST_REMAP_ON_CMD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr[23:8] == SELF && acc_addr[7:0] == 8'h04) |=> remap); // R8
    AST_CAP_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
        cap_sel |-> (acc_valid && acc_addr[23:8] == SELF && cap_off >= 8'(CAP_START))); // R9
    AST_SECBUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(sec_bus)); // R10
endmodule

bind cfgsp_top cfgsp_checker #(
    .BUS_NUM(BUS_NUM), .DEVFN(DEVFN), .CAP_START(CAP_START)
) chk_i (.*);

// File: tb/cfgsp_top_tb_top.sv
module cfgsp_top_tb_top;
    localparam logic [7:0] BUS = 8'h03;
    localparam logic [7:0] DF0 = 8'h21;
    localparam logic [7:0] DF1 = 8'h22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [23:0] acc_addr = 24'h0;
    logic [1:0]  acc_size = 2'd0;
    logic [31:0] acc_wdata = 32'h0;
    string       cur_tag = "R2";

    logic        rdv   [2];
    logic [31:0] rdd   [2];
    logic        rmp   [2];
    logic [7:0]  sbus  [2];
    logic        csel  [2];
    logic        cwr   [2];
    logic [7:0]  coff  [2];
    logic [1:0]  csz   [2];
    logic [31:0] cwd   [2];
    logic [31:0] crd   [2];

    assign crd[0] = {coff[0], 8'hCA, 8'hFE, coff[0]};
    assign crd[1] = {coff[1], 8'hCA, 8'hFE, coff[1]};

    cfgsp_top #(.BUS_NUM(3), .DEVFN('h21), .HDR_TYPE(8'h00), .CAP_EN(1)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rdv[0]), .rd_data(rdd[0]), .remap(rmp[0]), .sec_bus(sbus[0]),
        .cap_sel(csel[0]), .cap_write(cwr[0]), .cap_off(coff[0]), .cap_size(csz[0]),
        .cap_wdata(cwd[0]), .cap_rdata(crd[0]));

    cfgsp_top #(.BUS_NUM(3), .DEVFN('h22), .HDR_TYPE(8'h81), .CAP_EN(0)) brg_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rdv[1]), .rd_data(rdd[1]), .remap(rmp[1]), .sec_bus(sbus[1]),
        .cap_sel(csel[1]), .cap_write(cwr[1]), .cap_off(coff[1]), .cap_size(csz[1]),
        .cap_wdata(cwd[1]), .cap_rdata(crd[1]));

    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  mdl [2][256];
    logic        e_rdv [2];
    logic [31:0] e_rd  [2];
    logic        e_rmp [2];
    logic [7:0]  e_sec [2];
    string       e_tag [2];
    bit          mvalid = 0;

    function automatic bit is_bridge_k(input int k); return k == 1; endfunction
    function automatic bit cap_en_k(input int k);    return k == 0; endfunction
    function automatic logic [7:0] df_k(input int k); return (k == 0) ? DF0 : DF1; endfunction

    function automatic bit ro_byte(input int a, input bit bridge);
        if (a <= 3 || (a >= 8 && a <= 11) || a == 14 || a == 'h3D) return 1;
        if (a >= 'h2C && a <= 'h2F) return 1;
        if (bridge) return (a >= 'h38 && a <= 'h3B);
        return (a >= 'h10 && a <= 'h33);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 256; i++) mdl[k][i] = 8'h00;
            mdl[k][0] = 8'hCD; mdl[k][1] = 8'hAB; mdl[k][2] = 8'h34; mdl[k][3] = 8'h12;
            mdl[k][14] = is_bridge_k(k) ? 8'h81 : 8'h00;
            if (cap_en_k(k)) begin mdl[k][6] = 8'h10; mdl[k]['h34] = 8'h40; end
            e_rdv[k] = 0; e_rd[k] = 0; e_rmp[k] = 0; e_sec[k] = 0; e_tag[k] = "R4";
        end
    endtask

    task automatic model_step(input int k);
        int off, n, a;
        bit self, incap;
        logic [31:0] v;
        logic [7:0] b;
        off  = acc_addr[7:0];
        n    = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
        self = acc_valid && acc_addr[23:16] == BUS && acc_addr[15:8] == df_k(k);
        incap = cap_en_k(k) && off >= 'h40 && (off + n) < 'h50;
        e_rdv[k] = acc_valid && !acc_write;
        e_rmp[k] = 0;
        e_tag[k] = acc_valid ? cur_tag : "R2";
        if (acc_valid && !acc_write) begin
            if (!self) e_rd[k] = 32'hFFFF_FFFF;
            else if (incap) e_rd[k] = {8'(off), 8'hCA, 8'hFE, 8'(off)};
            else if (n == 4 && off <= 252)
                e_rd[k] = {mdl[k][off+3], mdl[k][off+2], mdl[k][off+1], mdl[k][off]};
            else if (n >= 2 && off <= 254) e_rd[k] = {16'h0, mdl[k][off+1], mdl[k][off]};
            else e_rd[k] = {24'h0, mdl[k][off]};
        end
        if (acc_valid && acc_write && self) begin
            if (n == 4 && ((off >= 'h10 && off <= 'h27) || (off >= 'h30 && off <= 'h33))) begin
                v = (off >= 'h30) ? ((acc_wdata & 32'hFFFF_F000) | (acc_wdata & 32'h1))
                                  : (acc_wdata & 32'hFFFF_FF00);
                for (int i = 0; i < 4; i++) mdl[k][off+i] = v[8*i +: 8];
                e_rmp[k] = 1;
            end else if (!incap) begin
                for (int i = 0; i < n; i++) begin
                    a = off + i;
                    b = acc_wdata[8*i +: 8];
                    if (a <= 255 && !ro_byte(a, is_bridge_k(k))) begin
                        if (a == 5) b = b & 8'h07;
                        if (a == 6) b = (b & 8'hA8) | (mdl[k][6] & 8'h10);
                        if (a == 7) b = b & 8'hF9;
                        mdl[k][a] = b;
                    end
                end
                if (off <= 5 && off + n - 1 >= 4) e_rmp[k] = 1;
            end
            if (is_bridge_k(k) && !incap) begin
                if (off == 'h19) e_sec[k] = acc_wdata[7:0];
                else if (off == 'h18 && n > 1) e_sec[k] = acc_wdata[15:8];
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
            mvalid <= 0;
        end else begin
            for (int k = 0; k < 2; k++) model_step(k);
            mvalid <= 1;
        end
    end

    // Compared every clock, away from the active edge.
    always @(negedge clk) begin
        if (mvalid) begin
            for (int k = 0; k < 2; k++) begin
                check(rdv[k] == e_rdv[k], e_tag[k], $sformatf("dut%0d rd_valid", k), 32'(rdv[k]), 32'(e_rdv[k]));
                if (e_rdv[k])
                    check(rdd[k] == e_rd[k], e_tag[k], $sformatf("dut%0d rd_data", k), rdd[k], e_rd[k]);
                check(rmp[k] == e_rmp[k], e_tag[k], $sformatf("dut%0d remap", k), 32'(rmp[k]), 32'(e_rmp[k]));
                check(sbus[k] == e_sec[k], e_tag[k], $sformatf("dut%0d sec_bus", k), 32'(sbus[k]), 32'(e_sec[k]));
            end
        end
    end

    task automatic acc(input bit wr, input logic [7:0] bus, input logic [7:0] df,
                       input logic [7:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
        int n;
        bit exp_cap;
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_addr = {bus, df, off};
        acc_size = sz; acc_wdata = wd; cur_tag = tag;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        exp_cap = (bus == BUS) && (df == DF0) && off >= 8'h40 && (int'(off) + n) < 'h50;
        #1;
        check(csel[0] == exp_cap, "R9", "cap_sel", 32'(csel[0]), 32'(exp_cap));
        check(csel[1] == 1'b0, "R9", "bridge cap_sel", 32'(csel[1]), 32'h0);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            acc_valid = 0; acc_write = 0; cur_tag = "R2";
        end
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle(2);
        // R4 reset contents
        acc(0, BUS, DF0, 8'h00, 2, 0, "R4");
        acc(0, BUS, DF0, 8'h04, 2, 0, "R4");
        acc(0, BUS, DF0, 8'h0C, 2, 0, "R4");
        acc(0, BUS, DF1, 8'h0C, 2, 0, "R4");
        acc(0, BUS, DF0, 8'h34, 0, 0, "R4");
        acc(0, BUS, DF1, 8'h34, 2, 0, "R4");
        // R1 misses
        acc(0, 8'h04, DF0, 8'h00, 2, 0, "R1");
        acc(0, BUS, 8'h23, 8'h00, 2, 0, "R1");
        acc(1, 8'h04, DF0, 8'h3C, 0, 32'h5A, "R1");
        acc(0, BUS, DF0, 8'h3C, 0, 0, "R1");
        // R2 little-endian, sizes
        acc(1, BUS, DF0, 8'h3C, 0, 32'h77, "R2");
        acc(0, BUS, DF0, 8'h00, 1, 0, "R2");
        acc(0, BUS, DF0, 8'h02, 3, 0, "R2");
        // R6 protected bytes
        acc(1, BUS, DF0, 8'h00, 2, 32'hFFFFFFFF, "R6");
        acc(1, BUS, DF0, 8'h0C, 2, 32'hFFFFFFFF, "R6");
        acc(1, BUS, DF1, 8'h2C, 2, 32'h11111111, "R6");
        acc(1, BUS, DF0, 8'h3C, 1, 32'hEEDD, "R6");
        acc(0, BUS, DF0, 8'h00, 2, 0, "R6");
        acc(0, BUS, DF0, 8'h0C, 2, 0, "R6");
        acc(0, BUS, DF0, 8'h3C, 2, 0, "R6");
        acc(1, BUS, DF0, 8'h10, 0, 32'h55, "R6");
        acc(1, BUS, DF1, 8'h10, 0, 32'h55, "R6");
        acc(1, BUS, DF0, 8'h38, 0, 32'h66, "R6");
        acc(1, BUS, DF1, 8'h38, 0, 32'h66, "R6");
        acc(0, BUS, DF0, 8'h10, 0, 0, "R6");
        acc(0, BUS, DF1, 8'h10, 0, 0, "R6");
        acc(0, BUS, DF0, 8'h38, 0, 0, "R6");
        acc(0, BUS, DF1, 8'h38, 0, 0, "R6");
        // R7 reserved bits, R8 command remap
        acc(1, BUS, DF0, 8'h04, 2, 32'hFFFFFFFF, "R7");
        acc(0, BUS, DF0, 8'h04, 2, 0, "R7");
        acc(1, BUS, DF0, 8'h06, 0, 32'h00, "R7");
        acc(0, BUS, DF0, 8'h04, 2, 0, "R7");
        acc(1, BUS, DF0, 8'h05, 0, 32'h03, "R8");
        acc(1, BUS, DF0, 8'h03, 2, 32'h01020304, "R8");
        acc(1, BUS, DF0, 8'h06, 1, 32'h0000, "R8");
        acc(1, BUS, DF1, 8'h04, 1, 32'h0106, "R8");
        idle(1);
        // R5 base and ROM masking
        acc(1, BUS, DF0, 8'h10, 2, 32'hFFFFFFFF, "R5");
        acc(1, BUS, DF0, 8'h24, 2, 32'h12345678, "R5");
        acc(1, BUS, DF0, 8'h30, 2, 32'hFFFFFFFF, "R5");
        acc(1, BUS, DF1, 8'h30, 2, 32'hABCDE7FE, "R5");
        acc(0, BUS, DF0, 8'h10, 2, 0, "R5");
        acc(0, BUS, DF0, 8'h24, 2, 0, "R5");
        acc(0, BUS, DF0, 8'h30, 2, 0, "R5");
        acc(0, BUS, DF1, 8'h30, 2, 0, "R5");
        // R3 width narrowing near top
        acc(1, BUS, DF0, 8'hFC, 2, 32'hA1B2C3D4, "R3");
        acc(1, BUS, DF1, 8'hFE, 2, 32'h99887766, "R3");
        acc(0, BUS, DF0, 8'hFC, 2, 0, "R3");
        acc(0, BUS, DF0, 8'hFD, 2, 0, "R3");
        acc(0, BUS, DF0, 8'hFE, 2, 0, "R3");
        acc(0, BUS, DF0, 8'hFF, 2, 0, "R3");
        acc(0, BUS, DF0, 8'hFF, 1, 0, "R3");
        acc(0, BUS, DF1, 8'hFC, 2, 0, "R3");
        // R9 capability window edges
        acc(0, BUS, DF0, 8'h40, 2, 0, "R9");
        acc(0, BUS, DF0, 8'h4B, 2, 0, "R9");
        acc(1, BUS, DF0, 8'h4C, 2, 32'hCAFEF00D, "R9");
        acc(0, BUS, DF0, 8'h4C, 2, 0, "R9");
        acc(1, BUS, DF0, 8'h44, 2, 32'hDEADBEEF, "R9");
        acc(0, BUS, DF0, 8'h4E, 0, 0, "R9");
        acc(0, BUS, DF0, 8'h4F, 0, 0, "R9");
        acc(0, BUS, DF0, 8'h3E, 1, 0, "R9");
        acc(0, BUS, DF1, 8'h40, 2, 0, "R9");
        // R10 secondary bus
        acc(1, BUS, DF1, 8'h19, 0, 32'h05, "R10");
        acc(1, BUS, DF1, 8'h18, 1, 32'h0700, "R10");
        acc(1, BUS, DF1, 8'h18, 2, 32'h11220933, "R10");
        acc(1, BUS, DF0, 8'h19, 0, 32'h44, "R10");
        acc(1, 8'h05, DF1, 8'h19, 0, 32'h44, "R10");
        acc(1, BUS, DF1, 8'h18, 0, 32'h44, "R10");
        acc(0, BUS, DF1, 8'h18, 2, 0, "R10");
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule